// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a watchdog timer that runs from one slow, free-running clock. Software controls it through a small write-only register port. A 16-bit command register accepts magic codes: one starts the watchdog, one refreshes the counter, and two open or close write access to the configuration registers. The configuration registers are a 3-bit divider select, a 12-bit reload value and a 12-bit window value.

Once the watchdog is started, a 12-bit down-counter steps once per prescaled tick. If the counter runs out, the block raises a one-cycle reset request and reloads the counter. The window value lets the watchdog catch software that refreshes too early. When it is not all-ones, a refresh that arrives while the counter is still above the window raises a reset request as well. The request goes to the chip's reset network, which lies outside this block.

The register port is a plain write strobe and accepts a write in every cycle. It has no back-pressure. The counter value and a running flag come out as plain status pins.

Top module: `keyed_window_wdog`

## Requirements
- R1: After reset, `count` is 0xFFF, `running` is 0 and `rst_req` is 0. The configuration resets to divider code 0, reload 0xFFF and window 0xFFF (window check off).
- R2: Writing 0xCCCC to the command register (address 0) sets `running` and loads `count` from the reload register. From then on, `count` falls by one every divider period: n cycles after the start edge it equals reload − floor(n/div).
- R3: The divider select at address 1 is a 3-bit code. Code c from 0 to 6 gives div = 2^(c+2), so 4 up to 256 cycles. Code 7 behaves exactly like code 6.
- R4: If the counter is at zero when a tick falls due, `rst_req` is high for exactly the one cycle that follows. This happens exactly (reload+1)·div cycles after a start or refresh, and `count` returns to the reload value at the same edge.
- R5: Writing 0xAAAA to the command register reloads `count` from the reload register and restarts the divider phase.
- R6: Writing 0x5555 opens write access to addresses 1 (divider), 2 (reload) and 3 (window), using the low bits of `wr_data`. Writing 0x0000 or 0xAAAA closes that access again.
- R7: A write to address 1, 2 or 3 while access is closed leaves the register unchanged.
- R8: When the window is not 0xFFF, a 0xAAAA write while `running` is set and `count` is above the window raises `rst_req` for one cycle. The same write with `count` at or below the window raises nothing. In both cases the counter reloads.
- R9: With the window at 0xFFF, a refresh never raises `rst_req`, whatever the counter value.
- R10: A command value other than the four defined codes changes nothing.
- R11: Once set, `running` stays set until the block is reset. A second 0xCCCC write while running does not reload the counter or restart the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow free-running tick clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | 0 command, 1 divider select, 2 reload, 3 window |
| wr_data | input | 16 | Write data |
| count | output | 12 | Current down-counter value |
| running | output | 1 | Watchdog has been started |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The in-module assertions check the following on every cycle:
- the counter holds between ticks and steps down by exactly one on a tick;
- it reloads after expiry and after a refresh or start;
- the running flag never falls;
- a reset request only occurs while running;
- a locked configuration register never changes.

The exact expiry time for each divider code, the code 7 alias, window faults and the rejection of unknown codes all depend on the sequence of writes. Only the bench scenarios, which sweep divider codes and reload values against arithmetic expectations, can show these.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int DATA_W = 16;

  localparam logic [DATA_W-1:0] CMD_START  = 16'hCCCC;
  localparam logic [DATA_W-1:0] CMD_KICK   = 16'hAAAA;
  localparam logic [DATA_W-1:0] CMD_OPEN   = 16'h5555;
  localparam logic [DATA_W-1:0] CMD_CLOSE  = 16'h0000;

  typedef enum logic [1:0] {
    ADDR_CMD    = 2'd0,
    ADDR_DIV    = 2'd1,
    ADDR_RELOAD = 2'd2,
    ADDR_WINDOW = 2'd3
  } wdg_addr_e;

  typedef struct packed {
    logic start;
    logic kick;
    logic open;
    logic close;
  } wdg_cmd_t;

endpackage

// File: rtl/wdg_cmd_decode.sv
module wdg_cmd_decode
  import wdg_pkg::*;
(
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wdg_cmd_t          cmd
);

  logic hit;

  always_comb begin
    hit       = wr_en && (wr_addr == ADDR_CMD);
    cmd.start = hit && (wr_data == CMD_START);
    cmd.kick  = hit && (wr_data == CMD_KICK);
    cmd.open  = hit && (wr_data == CMD_OPEN);
    cmd.close = hit && (wr_data == CMD_CLOSE);
  end

endmodule

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs
  import wdg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              open_cmd,
  input  logic              close_cmd,
  output logic [SEL_W-1:0]  div_sel,
  output logic [CNT_W-1:0]  reload,
  output logic [CNT_W-1:0]  window
);

  logic unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         unlocked <= 1'b0;
    else if (open_cmd)  unlocked <= 1'b1;
    else if (close_cmd) unlocked <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sel <= '0;
      reload  <= '1;
      window  <= '1;
    end else if (wr_en && unlocked) begin
      case (wr_addr)
        ADDR_DIV:    div_sel <= wr_data[SEL_W-1:0];
        ADDR_RELOAD: reload  <= wr_data[CNT_W-1:0];
        ADDR_WINDOW: window  <= wr_data[CNT_W-1:0];
        default:     ;
      endcase
    end
  end

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(div_sel) && $stable(reload) && $stable(window))); // R7

endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int SEL_W    = 3,
  parameter int MIN_LOG  = 2,
  parameter int MAX_CODE = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);

  localparam int MAX_LOG = MIN_LOG + MAX_CODE;

  logic [MAX_LOG-1:0] phase;
  logic [MAX_LOG-1:0] mask;
  int unsigned        eff_log;

  always_comb begin
    if (int'(div_sel) > MAX_CODE) eff_log = MAX_LOG;
    else                          eff_log = int'(div_sel) + MIN_LOG;
    for (int i = 0; i < MAX_LOG; i++) mask[i] = (i < eff_log);
    tick = run && !restart && ((phase & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (run)     phase <= phase + 1'b1;
  end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic             kick,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] window,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             fault
);

  logic win_on;

  always_comb begin
    win_on = (window != '1);
    expire = tick && (count == '0);
    fault  = run && kick && win_on && (count > window);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= '1;
    else if (load || expire)  count <= reload;
    else if (tick)            count <= count - 1'b1;
  end

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && count != '0) |=> (count == $past(count) - 1'b1)); // R2
  AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count == $past(reload))); // R4
  AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(reload))); // R5

endmodule

// File: rtl/keyed_window_wdog.sv
module keyed_window_wdog
  import wdg_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int SEL_W    = 3,
  parameter int MIN_LOG  = 2,
  parameter int MAX_CODE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [15:0]       wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              running,
  output logic              rst_req
);

  wdg_cmd_t         cmd;
  logic [SEL_W-1:0] div_sel;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] window;
  logic             start_go;
  logic             load;
  logic             tick;
  logic             expire;
  logic             fault;

  wdg_cmd_decode u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  wdg_cfg_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .open_cmd  (cmd.open),
    .close_cmd (cmd.close || cmd.kick),
    .div_sel   (div_sel),
    .reload    (reload),
    .window    (window)
  );

  assign start_go = cmd.start && !running;
  assign load     = start_go || cmd.kick;

  wdg_prescaler #(.SEL_W(SEL_W), .MIN_LOG(MIN_LOG), .MAX_CODE(MAX_CODE)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .restart (load),
    .div_sel (div_sel),
    .tick    (tick)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (running),
    .load   (load),
    .kick   (cmd.kick),
    .tick   (tick),
    .reload (reload),
    .window (window),
    .count  (count),
    .expire (expire),
    .fault  (fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (start_go) running <= 1'b1;
      rst_req <= expire || fault;
    end
  end

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running); // R11
  AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> running); // R4

endmodule

// File: tb/keyed_window_wdog_test.sv
module keyed_window_wdog_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [11:0] count;
  logic        running;
  logic        rst_req;

  int compared = 0;
  int mismatched = 0;

  keyed_window_wdog uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .running(running), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // caller stands at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int code, input int rel, input int win);
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'(code));
    wr(2'd2, 16'(rel));
    wr(2'd3, 16'(win));
  endtask

  function automatic int div_of(input int code);
    return 1 << ((code > 6 ? 6 : code) + 2);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 count", int'(count), 12'hFFF);
    check("R1 running", int'(running), 0);
    check("R1 rst_req", int'(rst_req), 0);

    // R10 unknown codes are ignored before start
    wr(2'd0, 16'h1234);
    wr(2'd0, 16'hCCCD);
    repeat (3) @(negedge clk);
    check("R10 running", int'(running), 0);
    check("R10 count", int'(count), 12'hFFF);

    // R7 locked reload write ignored; R1 default reload 0xFFF used at start
    wr(2'd2, 16'd5);
    wr(2'd0, 16'hCCCC);
    check("R7 count", int'(count), 12'hFFF);
    check("R2 running", int'(running), 1);

    // R2 R3 R4 sweep over divider codes and reload values
    for (int code = 0; code < 8; code++) begin
      for (int k = 0; k < 3; k++) begin
        int rel;
        int dv;
        int total;
        int bad;
        rel = (k == 0) ? 0 : (k == 1 ? 2 : 5);
        dv = div_of(code);
        total = dv * (rel + 1);
        bad = 0;
        do_reset();
        setup(code, rel, 12'hFFF);
        wr(2'd0, 16'hCCCC);
        for (int n = 1; n <= total; n++) begin
          @(negedge clk);
          if (n < total) begin
            if (rst_req !== 1'b0 || int'(count) != rel - n / dv) bad++;
          end else begin
            if (rst_req !== 1'b1 || int'(count) != rel) bad++;
          end
        end
        @(negedge clk);
        if (rst_req !== 1'b0) bad++;
        check($sformatf("R3 R4 code %0d reload %0d", code, rel), bad, 0);
      end
    end

    // R5 refresh reloads and restarts phase
    do_reset();
    setup(1, 30, 12'hFFF);
    wr(2'd0, 16'hCCCC);
    repeat (50) @(negedge clk);
    check("R2 count after 50", int'(count), 30 - 50 / 8);
    wr(2'd0, 16'hAAAA);
    check("R5 reload", int'(count), 30);
    check("R9 no pulse", int'(rst_req), 0);
    repeat (17) @(negedge clk);
    check("R5 phase", int'(count), 28);

    // R6 lock by close code and by refresh
    do_reset();
    setup(0, 7, 12'hFFF);
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'd9);
    wr(2'd0, 16'hCCCC);
    check("R6 close locks", int'(count), 7);
    wr(2'd0, 16'h5555);
    wr(2'd0, 16'hAAAA);
    wr(2'd2, 16'd11);
    wr(2'd0, 16'hAAAA);
    check("R6 refresh locks", int'(count), 7);
    wr(2'd0, 16'h5555);
    wr(2'd2, 16'd13);
    wr(2'd0, 16'hAAAA);
    check("R6 open allows", int'(count), 13);

    // R11 cannot be stopped or restarted
    do_reset();
    setup(0, 40, 12'hFFF);
    wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h1234);
    wr(2'd0, 16'hCCCC);
    repeat (5) @(negedge clk);
    check("R11 running", int'(running), 1);
    check("R11 count", int'(count), 38);

    // R8 window fault and legal refresh
    do_reset();
    setup(0, 20, 10);
    wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'hAAAA);
    check("R8 early pulse", int'(rst_req), 1);
    check("R8 reload", int'(count), 20);
    @(negedge clk);
    check("R8 pulse width", int'(rst_req), 0);
    repeat (44) @(negedge clk);
    wr(2'd0, 16'hAAAA);
    check("R8 legal kick", int'(rst_req), 0);
    check("R8 legal reload", int'(count), 20);

    // R9 window disabled allows early refresh
    do_reset();
    setup(0, 20, 12'hFFF);
    wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'hAAAA);
    check("R9 early ok", int'(rst_req), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule